// File: doc/BRIEF.md
# Pointer-Addressed Serial-Bus Register Slave

This block is a slave on a two-wire serial bus (SMBus style). Through it, a master reaches a bank of 8-bit registers that lives outside the block. A fast system clock oversamples the bus clock and data lines. The block detects start and stop conditions from those samples and checks the 7-bit device address of each transaction. It acknowledges bytes by pulling the data line low through an open-drain enable. The device address is taken from a strap input while reset is held. Later changes on the strap have no effect.

A write transaction always loads the first data byte into an internal pointer. A second data byte is stored into the register that the pointer selects. Any further bytes are refused. A read transaction returns the register the pointer already selects, and the pointer does not move. The register bank is reached through a pointer output, a read-data input and a single-cycle write strobe with write data.

The controller is one state machine with these states:
- `ST_IDLE`: bus free.
- `ST_ADDR`: shifting in the address byte.
- `ST_ADDR_ACK`: acknowledging the device address.
- `ST_WR_BYTE`: shifting in a write byte.
- `ST_WR_ACK`: acknowledging a write byte.
- `ST_RD_BYTE`: shifting out a read byte.
- `ST_RD_ACK`: sampling the master's acknowledge.
- `ST_IGNORE`: off the bus until the next start.

Transitions:
- A start condition moves any state to `ST_ADDR`.
- A stop condition moves any state to `ST_IDLE`.
- In `ST_ADDR`, the eighth falling clock goes to `ST_ADDR_ACK` on an address match and to `ST_IGNORE` otherwise.
- In `ST_ADDR_ACK`, the falling clock goes to `ST_RD_BYTE` or `ST_WR_BYTE` according to the R/W bit.
- In `ST_WR_BYTE`, the eighth falling clock goes to `ST_WR_ACK` for the first two data bytes and to `ST_IGNORE` after that.
- In `ST_WR_ACK`, the falling clock returns to `ST_WR_BYTE`.
- In `ST_RD_BYTE`, the eighth falling clock goes to `ST_RD_ACK`.
- In `ST_RD_ACK`, the falling clock returns to `ST_RD_BYTE` if the master acknowledged, and goes to `ST_IGNORE` otherwise.

Top module: `smb_reg_slave`

## Requirements
- R1: While reset is held and afterwards with the bus idle, `sda_oe` is 0, `reg_ptr` is 0 and `reg_we` is 0.
- R2: A start is SDA falling while SCL is high. The first byte after a start is a 7-bit address, MSB first, followed by R/W (0 = write, 1 = read). The slave pulls SDA low in the ninth clock only when the address equals the strapped address. Otherwise it drives nothing until the next start.
- R3: A write carrying one data byte loads that byte into `reg_ptr` and produces no `reg_we` pulse.
- R4: In a write, the second data byte is acknowledged. It is presented on `reg_wdata` with a one-cycle `reg_we` pulse while `reg_ptr` holds the first data byte.
- R5: Write data bytes after the second are not acknowledged and cause no register write.
- R6: A read returns, MSB first, the value on `reg_rdata` for the current `reg_ptr`. The read leaves `reg_ptr` unchanged.
- R7: When the master acknowledges a read byte, the next byte returns the same register again.
- R8: When the master does not acknowledge a read byte, the slave releases SDA and drives nothing more until the next start.
- R9: A repeated start in the middle of a byte discards that byte and restarts address matching. The pointer value is kept.
- R10: The device address is sampled from `strap_addr` while reset is asserted. Later changes on `strap_addr` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_addr | input | 7 | Device address strap, sampled during reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |
| reg_ptr | output | 8 | Pointer selecting the register in the bank |
| reg_rdata | input | 8 | Contents of the register selected by `reg_ptr` |
| reg_wdata | output | 8 | Data for a register write |
| reg_we | output | 1 | One-cycle register write strobe |

## Verification
A wrong state shows at the ports within one bus bit.
- A wrong address compare, or a write-byte counter that fails to saturate, shows as a wrong level on SDA during the very next acknowledge clock.
- A wrong transmit shift shows as a corrupted read bit one SCL period later.
- A pointer damaged by a read or by a repeated start shows on `reg_ptr` immediately, and in the data returned by the next read transaction.

// File: rtl/smb_pkg.sv
package smb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_IGNORE
    } smb_state_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES:0] pipe_q;

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= {pipe_q[STAGES-1:0], line_i};
    end

    assign level_o = pipe_q[STAGES-1];
    assign rise_o  = pipe_q[STAGES-1] & ~pipe_q[STAGES];
    assign fall_o  = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/smb_cond_det.sv
module smb_cond_det (
    input  logic scl_lvl,
    input  logic sda_rise,
    input  logic sda_fall,
    output logic start_o,
    output logic stop_o
);
    assign start_o = scl_lvl & sda_fall;
    assign stop_o  = scl_lvl & sda_rise;
endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave
    import smb_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] strap_addr,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [7:0]        reg_ptr,
    input  logic [7:0]        reg_rdata,
    output logic [7:0]        reg_wdata,
    output logic              reg_we
);
    localparam int BYTE_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    smb_state_e        state;
    logic [ADDR_W-1:0] dev_addr;
    logic [BYTE_W-1:0] rx_sr;
    logic [BYTE_W-1:0] tx_sr;
    logic [CNT_W-1:0]  bit_cnt;
    logic [1:0]        wr_idx;
    logic              rw_q;
    logic              mack_q;

    logic scl_lvl, scl_rise, scl_fall;
    logic sda_lvl, sda_rise, sda_fall;
    logic bus_start, bus_stop;

    smb_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i),
        .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
    );

    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i),
        .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
    );

    smb_cond_det u_cond (
        .scl_lvl(scl_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
        .start_o(bus_start), .stop_o(bus_stop)
    );

    // Strap capture: follows the pin only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) dev_addr <= strap_addr;
    end

    // State register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            rx_sr     <= '0;
            tx_sr     <= '0;
            bit_cnt   <= '0;
            wr_idx    <= '0;
            rw_q      <= 1'b0;
            mack_q    <= 1'b0;
            reg_ptr   <= '0;
            reg_wdata <= '0;
            reg_we    <= 1'b0;
        end else begin
            reg_we <= 1'b0;
            if (bus_start) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                wr_idx  <= '0;
            end else if (bus_stop) begin
                state <= ST_IDLE;
            end else begin
                unique case (state)
                    ST_IDLE, ST_IGNORE: ;
                    ST_ADDR: begin
                        if (scl_rise) begin
                            rx_sr   <= {rx_sr[BYTE_W-2:0], sda_lvl};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == LAST_BIT) begin
                            if (rx_sr[BYTE_W-1:1] == dev_addr) begin
                                rw_q  <= rx_sr[0];
                                state <= ST_ADDR_ACK;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (rw_q) begin
                                tx_sr <= reg_rdata;
                                state <= ST_RD_BYTE;
                            end else begin
                                state <= ST_WR_BYTE;
                            end
                        end
                    end
                    ST_WR_BYTE: begin
                        if (scl_rise) begin
                            rx_sr   <= {rx_sr[BYTE_W-2:0], sda_lvl};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == LAST_BIT) begin
                            if (wr_idx == 2'd0) begin
                                reg_ptr <= rx_sr;
                                state   <= ST_WR_ACK;
                            end else if (wr_idx == 2'd1) begin
                                reg_wdata <= rx_sr;
                                reg_we    <= 1'b1;
                                state     <= ST_WR_ACK;
                            end else begin
                                state <= ST_IGNORE;
                            end
                            if (wr_idx != 2'd2) wr_idx <= wr_idx + 1'b1;
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            state   <= ST_WR_BYTE;
                        end
                    end
                    ST_RD_BYTE: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall) begin
                            if (bit_cnt == LAST_BIT) state <= ST_RD_ACK;
                            else tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            mack_q <= ~sda_lvl;
                        end else if (scl_fall) begin
                            if (mack_q) begin
                                tx_sr   <= reg_rdata;
                                bit_cnt <= '0;
                                state   <= ST_RD_BYTE;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                endcase
            end
        end
    end

    // Output decode
    always_comb begin
        sda_oe = 1'b0;
        unique case (state)
            ST_ADDR_ACK, ST_WR_ACK: sda_oe = 1'b1;
            ST_RD_BYTE:             sda_oe = ~tx_sr[BYTE_W-1];
            default:                sda_oe = 1'b0;
        endcase
    end

    // R2
    oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_lvl);

    // R4
    we_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R6
    ptr_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(reg_ptr) |-> $past(state) == ST_WR_BYTE);

    // R8
    rd_ack_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_ACK) |-> !sda_oe);

    // R5
    ignore_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> (!sda_oe && !reg_we));
endmodule

// File: tb/test_smb_reg_slave.sv
module test_smb_reg_slave;
    localparam logic [6:0] STRAP = 7'h2C;
    localparam logic [6:0] ALT   = 7'h11;
    localparam time Q = 100ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] strap_addr = STRAP;
    logic       scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic [7:0] reg_ptr, reg_rdata, reg_wdata;
    logic       reg_we;
    logic [7:0] bank [256];

    int checks = 0;
    int errors = 0;

    always #10ns clk = ~clk;

    assign sda_line  = m_sda & ~sda_oe;
    assign reg_rdata = bank[reg_ptr];

    always @(posedge clk) if (reg_we) bank[reg_ptr] <= reg_wdata;

    smb_reg_slave i_smb_reg_slave (
        .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr),
        .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .reg_ptr(reg_ptr), .reg_rdata(reg_rdata),
        .reg_wdata(reg_wdata), .reg_we(reg_we)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; #Q; scl = 1'b1; #Q; m_sda = 1'b0; #Q; scl = 1'b0; #Q;
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; #Q; scl = 1'b1; #Q; m_sda = 1'b1; #Q;
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = v[i]; #Q; scl = 1'b1; #(2*Q); scl = 1'b0; #Q;
        end
    endtask

    task automatic send_byte(input logic [7:0] v, output bit ack);
        send_bits(v, 8);
        m_sda = 1'b1; #Q; scl = 1'b1; #Q; ack = ~sda_line; #Q; scl = 1'b0; #Q;
    endtask

    task automatic read_byte(output logic [7:0] v, input bit mack);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            #Q; scl = 1'b1; #Q; v[i] = sda_line; #Q; scl = 1'b0; #Q;
        end
        m_sda = ~mack; #Q; scl = 1'b1; #(2*Q); scl = 1'b0; #Q;
        m_sda = 1'b1;
    endtask

    task automatic reg_write(input logic [7:0] p, input logic [7:0] d, input string tag);
        bit a0, a1, a2;
        bus_start(); send_byte({STRAP, 1'b0}, a0); send_byte(p, a1); send_byte(d, a2); bus_stop();
        check(a0 && a1 && a2, tag, {a0, a1, a2}, 3'b111);
    endtask

    task automatic reg_read(output logic [7:0] v);
        bit a;
        bus_start(); send_byte({STRAP, 1'b1}, a); read_byte(v, 1'b0); bus_stop();
    endtask

    initial begin
        #(200000 * 20ns);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit         ack;
        logic [7:0] v, v2;
        for (int i = 0; i < 256; i++) bank[i] = 8'(i) ^ 8'hA5;
        #(5*Q);
        check(sda_oe == 1'b0 && reg_ptr == 8'h00 && reg_we == 1'b0, "R1 reset state",
              {sda_oe, reg_ptr, reg_we}, 0);
        rst_n = 1'b1;
        #(2*Q);
        check(sda_oe == 1'b0 && reg_ptr == 8'h00, "R1 idle after reset", {sda_oe, reg_ptr}, 0);

        // R2: sweep every 7-bit address, write direction
        for (int a = 0; a < 128; a++) begin
            bus_start(); send_byte({7'(a), 1'b0}, ack);
            if (a != STRAP) begin
                send_byte(8'h5A, ack);
                check(ack == 1'b0, "R2 mismatched address data stays silent", ack, 0);
            end else begin
                check(ack == 1'b1, "R2 matching address acked", ack, 1);
            end
            bus_stop();
        end
        check(reg_ptr == 8'h00, "R2 no pointer change from foreign traffic", reg_ptr, 0);

        // R10: strap change after reset ignored
        strap_addr = ALT;
        bus_start(); send_byte({ALT, 1'b0}, ack); bus_stop();
        check(ack == 1'b0, "R10 new strap value not adopted", ack, 0);
        bus_start(); send_byte({STRAP, 1'b0}, ack); bus_stop();
        check(ack == 1'b1, "R10 reset-time address kept", ack, 1);

        // R3: pointer-only write
        bus_start(); send_byte({STRAP, 1'b0}, ack); send_byte(8'h07, ack); bus_stop();
        check(reg_ptr == 8'h07, "R3 pointer loaded", reg_ptr, 8'h07);
        check(bank[7] == (8'h07 ^ 8'hA5), "R3 register untouched", bank[7], 8'h07 ^ 8'hA5);

        // R4 / R6: write then read back 16 registers
        for (int p = 0; p < 16; p++) reg_write(8'(p), 8'((p * 37 + 5) & 8'hFF), "R4 write acks");
        for (int p = 0; p < 16; p++) begin
            check(bank[p] == 8'((p * 37 + 5) & 8'hFF), "R4 register stored", bank[p], (p * 37 + 5) & 8'hFF);
            bus_start(); send_byte({STRAP, 1'b0}, ack); send_byte(8'(p), ack); bus_stop();
            reg_read(v);
            check(v == 8'((p * 37 + 5) & 8'hFF), "R6 read data", v, (p * 37 + 5) & 8'hFF);
            check(reg_ptr == 8'(p), "R6 pointer unchanged by read", reg_ptr, p);
        end
        reg_read(v);
        check(v == 8'((15 * 37 + 5) & 8'hFF), "R6 read without pointer write", v, (15 * 37 + 5) & 8'hFF);

        // R7 / R8: acknowledged read repeats same register, nack releases
        bus_start(); send_byte({STRAP, 1'b1}, ack);
        read_byte(v, 1'b1); read_byte(v2, 1'b0);
        check(v == v2 && v == 8'((15 * 37 + 5) & 8'hFF), "R7 repeated register", v2, v);
        check(sda_oe == 1'b0, "R8 SDA released after nack", sda_oe, 0);
        send_bits(8'h00, 4);
        check(sda_oe == 1'b0, "R8 silent until next start", sda_oe, 0);
        bus_stop();

        // R5: third data byte refused
        bus_start(); send_byte({STRAP, 1'b0}, ack); send_byte(8'h03, ack);
        send_byte(8'h11, ack); send_byte(8'h22, ack);
        check(ack == 1'b0, "R5 third byte not acked", ack, 0);
        bus_stop();
        check(bank[3] == 8'h11, "R5 register keeps second byte", bank[3], 8'h11);

        // R9: repeated start mid-byte, pointer kept
        bus_start(); send_byte({STRAP, 1'b0}, ack); send_byte(8'h05, ack);
        send_bits(8'hFF, 4);
        bus_start(); send_byte({STRAP, 1'b1}, ack);
        check(ack == 1'b1, "R9 address re-matched after repeated start", ack, 1);
        read_byte(v, 1'b0); bus_stop();
        check(v == 8'((5 * 37 + 5) & 8'hFF), "R9 pointer kept", v, (5 * 37 + 5) & 8'hFF);
        bus_start(); send_byte({STRAP, 1'b0}, ack); send_bits(8'h00, 3);
        bus_start(); send_byte({STRAP, 1'b1}, ack); read_byte(v, 1'b0); bus_stop();
        check(reg_ptr == 8'h05 && v == 8'((5 * 37 + 5) & 8'hFF), "R9 partial pointer byte discarded",
              reg_ptr, 8'h05);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule